// File: doc/BRIEF.md
# I2C Master Interrupt and SCL Stuck-Low Supervisor

This unit sits beside the byte engine of an I2C master and turns that engine's single-cycle event pulses into software-visible state. Three event sources are caught in a sticky status register: a slave that does not acknowledge its address, the completion of a byte, and a clock line held low for too long. Software clears each one by writing a one to its bit. An enable register selects which of the latched events may drive the single level-sensitive interrupt line. A second status register keeps a sticky flag for a data byte that was not acknowledged, together with a live bus-idle indication. Reading that register clears the sticky flag.

The unit also holds the bus timing register. Its low byte holds the bit-period count that the byte engine uses, for example 0x64 for standard rate or 0x19 for fast rate. Its high byte holds the limit for the clock-low watchdog. The watchdog measures how long the clock line stays continuously low while a transfer is active. When that time reaches the limit, it raises the timeout event once. Software normally programs a limit of 128.

Register access is a simple single-cycle port. A write takes effect at the clock edge. Read data is combinational from the selected register, and a read's side effect takes effect at the edge. Address 0 selects event status, 1 the interrupt enables, 2 the timing register and 3 the controller status. When a write and a read are requested in the same cycle, the write wins.

Top module: `i2c_irq_tmo_unit`

## Requirements
- R1: Event status reads at address 0 with bit 0 = address not acknowledged, bit 1 = byte finished, bit 2 = clock-low timeout, and bits 15:3 read as zero. An event pulse sets its bit, and the bit stays set until software clears it.
- R2: A write to address 0 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged. Writing 0x0007 clears all three bits.
- R3: If an event pulse arrives in the same cycle as a write that clears its bit, the bit is set after that edge.
- R4: `irq` is high exactly when some status bit is set and its enable bit is also set. With the enables at 0, `irq` stays low whatever the status holds, and it stays high until every enabled set bit is cleared.
- R5: The enable register at address 1 stores write-data bits 2:0 at the same positions as the status bits, and its bits 15:3 read as zero.
- R6: The timing register at address 2 is a full 16-bit read/write register. Bits 15:8 hold the watchdog limit L.
- R7: With L > 0, the timeout bit is set at the edge after `xferActive`=1 and `sclIn`=0 have been held for L*PRESCALE consecutive edges (PRESCALE defaults to 4). It is set at most once per continuous low interval, even if software clears it during that interval.
- R8: A cycle with `sclIn`=1 or `xferActive`=0 restarts the watchdog measurement from zero.
- R9: A limit of L = 0 disables the watchdog, so the timeout bit is never set.
- R10: The controller status at address 3 has bit 0 = sticky data not-acknowledged flag (set by `evDataNack`) and bit 1 = live `busIdle`. A read at address 3 clears bit 0 at the edge, unless a new `evDataNack` arrives in that same cycle.
- R11: After reset the status, enable and timing registers are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects at the edge) |
| regAddr | input | 2 | Register select |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data of the selected register |
| evAddrNack | input | 1 | Pulse: address not acknowledged |
| evByteEnd | input | 1 | Pulse: byte finished |
| evDataNack | input | 1 | Pulse: data byte not acknowledged |
| busIdle | input | 1 | Live bus-idle level from the byte engine |
| xferActive | input | 1 | A transfer is in progress |
| sclIn | input | 1 | Sampled clock line level |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- An event pulse is always latched, even when it collides with a clear.
- A clear that meets no event clears its bit.
- Status never changes without a cause.
- `irq` stays low while all enables are off, and it only falls after a write to the status or enable register.
- The watchdog fires as a single pulse, only while the clock line is low during a transfer, and never with a zero limit.

Only the bench scenarios can show the following:
- The exact edge on which the timeout bit appears.
- That a cleared timeout stays clear for the rest of the low interval.
- That a one-cycle high glitch restarts the measurement.
- The read-to-clear behaviour of the controller status register.

// File: rtl/i2cirq_pkg.sv
`timescale 1ns/1ps
package i2cirq_pkg;
  localparam int EV_W         = 3;
  localparam int EV_ADDR_NACK = 0;
  localparam int EV_BYTE_END  = 1;
  localparam int EV_SCL_TMO   = 2;

  typedef enum logic [1:0] {
    SEL_STATUS   = 2'd0,
    SEL_ENABLE   = 2'd1,
    SEL_TIMING   = 2'd2,
    SEL_CTRLSTAT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrStatus;
    logic    wrEnable;
    logic    wrTiming;
    logic    rdCtrlStat;
    regSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/i2cirq_ctrl.sv
`timescale 1ns/1ps
module i2cirq_ctrl
  import i2cirq_pkg::*;
(
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  output regStrobe_t strb
);
  regSel_e sel;

  always_comb begin
    sel             = regSel_e'(regAddr);
    strb.rdSel      = sel;
    strb.wrStatus   = regWrEn && (sel == SEL_STATUS);
    strb.wrEnable   = regWrEn && (sel == SEL_ENABLE);
    strb.wrTiming   = regWrEn && (sel == SEL_TIMING);
    // a write in the same cycle takes priority over the read side effect
    strb.rdCtrlStat = regRdEn && !regWrEn && (sel == SEL_CTRLSTAT);
  end
endmodule

// File: rtl/i2cirq_scl_watchdog.sv
`timescale 1ns/1ps
module i2cirq_scl_watchdog #(
  parameter int PRESCALE = 4,
  parameter int LIMIT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xferActive,
  input  logic               sclIn,
  input  logic [LIMIT_W-1:0] limit,
  output logic               hit
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]      preCnt;
  logic [LIMIT_W-1:0] unitCnt;
  logic               fired;
  logic               lowActive;
  logic               atLimit;
  logic               preWrap;

  always_comb begin
    lowActive = xferActive && !sclIn;
    atLimit   = (unitCnt >= limit);
    preWrap   = (preCnt == PRE_LAST);
    hit       = lowActive && (limit != '0) && atLimit && !fired;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      unitCnt <= '0;
      fired   <= 1'b0;
    end else if (!lowActive) begin
      preCnt  <= '0;
      unitCnt <= '0;
      fired   <= 1'b0;
    end else begin
      if (hit) fired <= 1'b1;
      if (!atLimit) begin
        preCnt <= preWrap ? '0 : preCnt + PW'(1);
        if (preWrap) unitCnt <= unitCnt + LIMIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/i2cirq_datapath.sv
`timescale 1ns/1ps
module i2cirq_datapath
  import i2cirq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evAddrNack,
  input  logic              evByteEnd,
  input  logic              evDataNack,
  input  logic              sclHit,
  input  logic              busIdle,
  output logic [EV_W-1:0]   statusVec,
  output logic [EV_W-1:0]   enableVec,
  output logic [DATA_W-1:0] timingVec,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [EV_W-1:0] setVec;
  logic [EV_W-1:0] statusNext;
  logic            dataNackQ;

  always_comb begin
    setVec               = '0;
    setVec[EV_ADDR_NACK] = evAddrNack;
    setVec[EV_BYTE_END]  = evByteEnd;
    setVec[EV_SCL_TMO]   = sclHit;
  end

  // per-bit write-one-to-clear cell, set wins over clear
  for (genvar b = 0; b < EV_W; b++) begin : g_evCell
    always_comb
      statusNext[b] = (statusVec[b] && !(strb.wrStatus && wdata[b])) || setVec[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusVec <= '0;
      enableVec <= '0;
      timingVec <= '0;
      dataNackQ <= 1'b0;
    end else begin
      statusVec <= statusNext;
      if (strb.wrEnable) enableVec <= wdata[EV_W-1:0];
      if (strb.wrTiming) timingVec <= wdata;
      dataNackQ <= (dataNackQ && !strb.rdCtrlStat) || evDataNack;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      SEL_STATUS:   rdata[EV_W-1:0] = statusVec;
      SEL_ENABLE:   rdata[EV_W-1:0] = enableVec;
      SEL_TIMING:   rdata           = timingVec;
      SEL_CTRLSTAT: rdata[1:0]      = {busIdle, dataNackQ};
      default:      rdata           = '0;
    endcase
  end

  assign irq = |(statusVec & enableVec);
endmodule

// File: rtl/i2c_irq_tmo_unit.sv
`timescale 1ns/1ps
module i2c_irq_tmo_unit
  import i2cirq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LIMIT_W  = 8,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evAddrNack,
  input  logic              evByteEnd,
  input  logic              evDataNack,
  input  logic              busIdle,
  input  logic              xferActive,
  input  logic              sclIn,
  output logic              irq
);
  localparam int LIMIT_LSB = DATA_W - LIMIT_W;

  regStrobe_t          strb;
  logic [EV_W-1:0]     statusVec;
  logic [EV_W-1:0]     enableVec;
  logic [DATA_W-1:0]   timingVec;
  logic [LIMIT_W-1:0]  tmoLimit;
  logic                sclHit;

  assign tmoLimit = timingVec[DATA_W-1:LIMIT_LSB];

  i2cirq_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  i2cirq_scl_watchdog #(.PRESCALE(PRESCALE), .LIMIT_W(LIMIT_W)) u_wdog (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .sclIn      (sclIn),
    .limit      (tmoLimit),
    .hit        (sclHit)
  );

  i2cirq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (regWdata),
    .evAddrNack (evAddrNack),
    .evByteEnd  (evByteEnd),
    .evDataNack (evDataNack),
    .sclHit     (sclHit),
    .busIdle    (busIdle),
    .statusVec  (statusVec),
    .enableVec  (enableVec),
    .timingVec  (timingVec),
    .rdata      (regRdata),
    .irq        (irq)
  );
endmodule

// File: rtl/i2cirq_checker.sv
`timescale 1ns/1ps
module i2cirq_checker #(
  parameter int LIMIT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [1:0]         regAddr,
  input logic [15:0]        regWdata,
  input logic               evAddrNack,
  input logic               evByteEnd,
  input logic               xferActive,
  input logic               sclIn,
  input logic [2:0]         statusVec,
  input logic [2:0]         enableVec,
  input logic [LIMIT_W-1:0] limit,
  input logic               hit,
  input logic               irq
);
  logic wrStat;
  logic wrEn1;
  assign wrStat = regWrEn && (regAddr == 2'd0);
  assign wrEn1  = regWrEn && (regAddr == 2'd1);

  assert_addr_nack_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    evAddrNack |=> statusVec[0]);
  assert_byte_end_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    evByteEnd |=> statusVec[1]);
  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && regWdata[1] && !evByteEnd) |=> !statusVec[1]);
  assert_status_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStat && !evAddrNack && !evByteEnd && !hit) |=> $stable(statusVec));
  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enableVec == 3'b000) |-> !irq);
  assert_irq_fall_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(wrStat || wrEn1));
  assert_hit_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> !hit);
  assert_hit_needs_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (xferActive && !sclIn));
  assert_zero_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (limit == '0) |-> !hit);
endmodule

bind i2c_irq_tmo_unit i2cirq_checker #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .evAddrNack (evAddrNack),
  .evByteEnd  (evByteEnd),
  .xferActive (xferActive),
  .sclIn      (sclIn),
  .statusVec  (statusVec),
  .enableVec  (enableVec),
  .limit      (tmoLimit),
  .hit        (sclHit),
  .irq        (irq)
);

// File: tb/i2c_irq_tmo_unit_bench.sv
`timescale 1ns/1ps
module i2c_irq_tmo_unit_bench;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 0, regRdEn = 0;
  logic [1:0]  regAddr = 0;
  logic [15:0] regWdata = 0;
  logic [15:0] regRdata;
  logic        evAddrNack = 0, evByteEnd = 0, evDataNack = 0;
  logic        busIdle = 0, xferActive = 0, sclIn = 1;
  logic        irq;

  always #2 clk = ~clk;

  i2c_irq_tmo_unit u_i2c_irq_tmo_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .evAddrNack(evAddrNack), .evByteEnd(evByteEnd), .evDataNack(evDataNack),
    .busIdle(busIdle), .xferActive(xferActive), .sclIn(sclIn), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [2:0]  mSt = 0, mEn = 0;
  logic [15:0] mTm = 0;
  logic        mCs = 0;
  bit          chkIrq = 1;
  bit          chkRd = 0;
  logic        vAct = 0, vScl = 1, vIdle = 0;
  logic [15:0] lastRd;
  bit          done = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {13'b0, mSt};
      2'd1: return {13'b0, mEn};
      2'd2: return mTm;
      default: return {14'b0, vIdle, mCs};
    endcase
  endfunction

  function automatic string reqOf(input logic [1:0] a);
    case (a)
      2'd0: return "R1";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R10";
    endcase
  endfunction

  // one clock: check irq from the previous edge, drive, sample read, take the edge, update model
  task automatic cyc(input logic we, input logic re, input logic [1:0] a, input logic [15:0] wd,
                     input logic eA, input logic eB, input logic eD);
    @(negedge clk);
    if (chkIrq) chk("R4 irq", {15'b0, irq}, {15'b0, |(mSt & mEn)});
    regWrEn = we; regRdEn = re; regAddr = a; regWdata = wd;
    evAddrNack = eA; evByteEnd = eB; evDataNack = eD;
    busIdle = vIdle; xferActive = vAct; sclIn = vScl;
    #1;
    lastRd = regRdata;
    if (chkRd && re && !we) chk(reqOf(a), regRdata, expRead(a));
    @(posedge clk);
    if (we && a == 2'd0) mSt = mSt & ~wd[2:0];
    mSt = mSt | {1'b0, eB, eA};
    if (we && a == 2'd1) mEn = wd[2:0];
    if (we && a == 2'd2) mTm = wd;
    mCs = (mCs & !(re && !we && a == 2'd3)) | eD;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc(1, 0, a, d, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(0, 1, a, 16'h0, 0, 0, 0);
  endtask

  task automatic idleN(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 16'h0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R11 reset state
    @(negedge clk);
    chk("R11 irq", {15'b0, irq}, 16'h0);
    rd(2'd0); chk("R11 status", lastRd, 16'h0);
    rd(2'd1); chk("R11 enable", lastRd, 16'h0);
    rd(2'd2); chk("R11 timing", lastRd, 16'h0);

    // R1/R4: single pulse latched, irq held until cleared
    wr(2'd1, 16'hFFFA);
    rd(2'd1); chk("R5 enable readback", lastRd, 16'h0002);
    cyc(0, 0, 0, 0, 0, 1, 0);
    idleN(3);
    rd(2'd0); chk("R1 byte end latched", lastRd, 16'h0002);
    @(negedge clk); chk("R4 irq held", {15'b0, irq}, 16'h1);
    cyc(0, 0, 0, 0, 1, 0, 0);
    wr(2'd0, 16'h0002);
    @(negedge clk); chk("R4 irq low with only disabled bit set", {15'b0, irq}, 16'h0);
    rd(2'd0); chk("R2 selective clear", lastRd, 16'h0001);
    // R3 collision
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 2'd0, 16'h0002, 0, 1, 0);
    rd(2'd0); chk("R3 set wins over clear", lastRd, 16'h0003);
    wr(2'd0, 16'h0007);
    rd(2'd0); chk("R2 clear all", lastRd, 16'h0000);
    // R4 enables zero
    wr(2'd1, 16'h0000);
    cyc(0, 0, 0, 0, 1, 1, 0);
    @(negedge clk); chk("R4 masked irq", {15'b0, irq}, 16'h0);
    wr(2'd0, 16'h0007);
    // R10 read-to-clear
    vIdle = 1;
    cyc(0, 0, 0, 0, 0, 0, 1);
    rd(2'd3); chk("R10 sticky nack and idle", lastRd, 16'h0003);
    rd(2'd3); chk("R10 cleared by read", lastRd, 16'h0002);
    cyc(0, 1, 2'd3, 0, 0, 0, 1);
    rd(2'd3); chk("R10 event during read kept", lastRd, 16'h0003);
    vIdle = 0;

    // watchdog, limit 3 (status bit 2 not tracked by the model here)
    chkIrq = 0;
    wr(2'd2, 16'h0319);
    rd(2'd2); chk("R6 timing readback", lastRd, 16'h0319);
    vAct = 1; vScl = 0;
    idleN(3 * P);
    rd(2'd0); chk("R7 not yet at limit", lastRd & 16'h4, 16'h0);
    rd(2'd0); chk("R7 timeout set", lastRd & 16'h4, 16'h4);
    wr(2'd0, 16'h0004);
    idleN(20);
    rd(2'd0); chk("R7 only once per low interval", lastRd & 16'h4, 16'h0);
    vScl = 1; idleN(1); vScl = 0;
    idleN(10);
    vScl = 1; idleN(1); vScl = 0;
    idleN(3 * P);
    rd(2'd0); chk("R8 glitch restarts count", lastRd & 16'h4, 16'h0);
    rd(2'd0); chk("R8 full interval after glitch", lastRd & 16'h4, 16'h4);
    wr(2'd0, 16'h0004);
    vScl = 1; idleN(1); vScl = 0; vAct = 0;
    idleN(30);
    rd(2'd0); chk("R8 inactive transfer ignored", lastRd & 16'h4, 16'h0);
    vAct = 1;
    wr(2'd2, 16'h0064);
    idleN(60);
    rd(2'd0); chk("R9 zero limit disables", lastRd & 16'h4, 16'h0);
    vAct = 0; vScl = 1;
    wr(2'd0, 16'h0007);
    mSt = 0;
    chkIrq = 1;

    // constrained random register traffic and events, no timeouts
    chkRd = 1;
    for (int i = 0; i < 600; i++) begin
      int k;
      logic we, re;
      k = $urandom % 4;
      we = (k == 0);
      re = (k == 1);
      vIdle = 1'($urandom % 2);
      cyc(we, re, 2'($urandom % 4), 16'($urandom),
          ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0);
    end
    chkRd = 0;

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule